// File: doc/BRIEF.md
# Object Relocation Forwarding Unit

This block moves the live objects of one heap page (the source page) into a fresh destination page. New locations are handed out by a bump pointer. For every moved object it records where the object now lives. Processors that hold a stale pointer send the old address on a lookup port and get the new one back. If the object has not been moved yet, the unit moves it first and answers afterwards, so a requester always receives a usable address and sees only a longer wait.

A command gives the source and destination page numbers. From then on a background engine walks the source page in ascending address order. It reads each object's header to learn the object's size and copies the object one word per memory transaction. A lookup that targets the source page takes priority over the walk at the next object boundary. When the walk reaches the end of the page, the unit posts every fixed-size block of the source page to a free-list write port. It then goes idle. The mapping stays available for lookups until the next command.

Addresses are word addresses. With the default parameters an address is 10 bits wide, the page number is bits [9:6] (64-word pages) and free blocks are 16 words. An object starts with a header word, and header bits [6:0] give the object's length in words, header included. A header whose length is 0 marks the end of the objects in a page. Lookups are assumed to name object start addresses, and the live data of a page is assumed to fit in one destination page. A requester keeps at most one lookup outstanding.

Top module: `reloc_fwd_unit`

## Requirements
- R1: While reset is held and right after it, `busy`, `rsp_valid`, `mem_req` and `fl_we` are low.
- R2: A lookup whose page (address bits [9:6]) is not the current source page, or that arrives before any command, returns the same address. `rsp_valid` rises at the clock edge that follows the edge that captured `lk_valid`.
- R3: With no lookups during an evacuation, objects are taken in ascending source address order. Each one is placed at the destination page base plus the summed lengths (header bits [6:0]) of the objects before it. The walk stops at a length-0 header or at the end of the page.
- R4: Every word of a moved object is read from the source and then written to the matching word of its new location, one word per transaction. Writes go only into the destination page.
- R5: While the unit is idle after an evacuation, a lookup of a moved object returns its new address with the same one-edge latency as R2.
- R6: A lookup of a source-page object that has not been moved is served before the walk continues. That object goes at the current bump position, the mapping is recorded, and the response carries the new address. The walk later skips that object.
- R7: A lookup of an object that is being copied at that moment waits for the copy to finish and returns that copy's address. No object is copied twice, so the number of destination writes equals the summed lengths of the live objects.
- R8: After the walk ends and before going idle, the unit makes one free-list write per 16-word block of the source page, in ascending address order, with no memory transaction after the first one. `busy` then falls.
- R9: A command presented while `busy` is high is ignored. The running evacuation finishes unchanged, and the page named by the ignored command is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Start evacuating a page (taken only when idle) |
| cmd_src_page | input | 4 | Page to evacuate |
| cmd_dst_page | input | 4 | Page that receives the objects |
| busy | output | 1 | Evacuation in progress |
| lk_valid | input | 1 | Lookup request, one cycle |
| lk_addr | input | 10 | Old object address |
| rsp_valid | output | 1 | Lookup answer, one cycle |
| rsp_addr | output | 10 | New (or unchanged) address |
| mem_req | output | 1 | Memory transaction this cycle |
| mem_we | output | 1 | 1 = write, 0 = read (data returns next cycle) |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| fl_we | output | 1 | Free-list entry write |
| fl_addr | output | 10 | Base address of a freed block |

## Verification
The bench covers the lookup that arrives in the same cycle as the command for an object far down the page. A unit that let the walk go first would put that object last instead of at the destination base. It also sends a lookup for the object the walk is copying at that moment. A unit that did not wait would return a stale or second address, and one that copied twice would make more destination writes than the live data needs. The other cases are a command given while busy, which a faulty unit would start on top of the running one, and free-list writes that come too early or out of order. Every write is compared with the source word read just before it.

// File: rtl/rfu_pkg.sv
// Package: shared state encoding for the relocation forwarding unit.
// Assumes nothing beyond standard SystemVerilog.
package rfu_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a command, lookups answered from the table
        ST_PICK,   // object boundary: choose a lookup copy, the walk or the free list
        ST_HDR,    // issue header read
        ST_HDRW,   // header data returns
        ST_RD,     // read one object word
        ST_WR,     // write that word to the destination
        ST_FREE    // post freed blocks
    } rfu_state_e;
endpackage

// File: rtl/rfu_fwd_table.sv
// Forwarding table: one entry per word offset of the source page, holding a
// valid bit and the destination offset. Assumes the destination page number is
// kept by the caller. Cleared in one cycle when a new evacuation starts.
module rfu_fwd_table #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [PAGE_W-1:0] wr_off,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic              rd_hit,
    output logic [PAGE_W-1:0] rd_off
);
    localparam int ENTRIES = 1 << PAGE_W;

    logic [ENTRIES-1:0] valid_q;
    logic [PAGE_W-1:0]  off_q [ENTRIES];

    // Valid bits: cleared by reset or a new command, set when a copy completes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) valid_q <= '0;
        else if (wr_en)    valid_q[wr_idx] <= 1'b1;
    end

    // Offset storage: written alongside the valid bit.
    always_ff @(posedge clk) begin
        if (wr_en) off_q[wr_idx] <= wr_off;
    end

    assign rd_hit = valid_q[rd_idx];
    assign rd_off = off_q[rd_idx];

    // R7: an entry is written once per evacuation, so no object is copied twice.
    a_r7_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !clr |-> !valid_q[wr_idx]);
endmodule

// File: rtl/rfu_lookup_front.sv
// Lookup front end: holds one outstanding lookup. Addresses outside the active
// source page are answered at once with the same address; the rest wait for
// the engine's answer. Assumes the requester keeps at most one lookup pending.
module rfu_lookup_front #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              page_active,
    input  logic [ADDR_W-PAGE_W-1:0] src_page,
    input  logic              ans_valid,
    input  logic [ADDR_W-1:0] ans_addr,
    output logic              pend_in_page,
    output logic [PAGE_W-1:0] pend_off,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr
);
    logic              pend_v;
    logic [ADDR_W-1:0] pend_addr;

    assign pend_in_page = pend_v && page_active && (pend_addr[ADDR_W-1:PAGE_W] == src_page);
    assign pend_off     = pend_addr[PAGE_W-1:0];

    // Capture a request, then retire it with a one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (pend_v && (!pend_in_page || ans_valid)) begin
                rsp_valid <= 1'b1;
                rsp_addr  <= pend_in_page ? ans_addr : pend_addr;
                pend_v    <= 1'b0;
            end else if (lk_valid && !pend_v) begin
                pend_v    <= 1'b1;
                pend_addr <= lk_addr;
            end
        end
    end

    // R2: a response is a single-cycle pulse.
    a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R2: a response always retires a request held in the previous cycle.
    a_r2_rsp_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(pend_v));
endmodule

// File: rtl/rfu_evac_engine.sv
// Evacuation engine: walks the source page in address order, copies live
// objects word by word into the destination page using a bump pointer, serves
// copy-on-lookup at object boundaries and finally posts freed blocks. Assumes
// one-cycle memory read latency, headers with the length in bits [PAGE_W:0],
// and live data that fits in one page.
module rfu_evac_engine
    import rfu_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 6,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-PAGE_W-1:0] cmd_src,
    input  logic [ADDR_W-PAGE_W-1:0] cmd_dst,
    output logic              busy,
    output logic              page_active,
    output logic [ADDR_W-PAGE_W-1:0] src_page,
    input  logic              pend_in_page,
    input  logic [PAGE_W-1:0] pend_off,
    output logic              ans_valid,
    output logic [ADDR_W-1:0] ans_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              tb_clr,
    output logic              tb_wr_en,
    output logic [PAGE_W-1:0] tb_wr_idx,
    output logic [PAGE_W-1:0] tb_wr_off,
    output logic [PAGE_W-1:0] tb_rd_idx,
    input  logic              tb_rd_hit,
    input  logic [PAGE_W-1:0] tb_rd_off
);
    localparam int PG_W = ADDR_W - PAGE_W;
    localparam int NB_W = PAGE_W - BLK_W;
    localparam logic [PAGE_W:0] PAGE_WORDS = (PAGE_W+1)'(1 << PAGE_W);
    localparam logic [ADDR_W-1:0] BLK_WORDS = ADDR_W'(1 << BLK_W);

    rfu_state_e        state;
    logic [PG_W-1:0]   dst_pg;
    logic [PAGE_W:0]   walk_ptr, cur_size, idx, bump;
    logic [PAGE_W-1:0] cur_obj;
    logic              walk_done, demand;
    logic [NB_W-1:0]   fl_cnt;
    logic [PAGE_W:0]   hsize;
    logic              last_word, at_boundary;
    logic [PAGE_W-1:0] rd_off, wr_off;

    assign hsize       = mem_rdata[PAGE_W:0];
    assign last_word   = (idx == cur_size - 1'b1);
    assign at_boundary = (state == ST_IDLE) || (state == ST_PICK);
    assign rd_off      = cur_obj + idx[PAGE_W-1:0];
    assign wr_off      = bump[PAGE_W-1:0] + idx[PAGE_W-1:0];
    assign busy        = (state != ST_IDLE);

    // Table access: the pending lookup at boundaries, the current object otherwise.
    assign tb_rd_idx = at_boundary ? pend_off : cur_obj;
    assign tb_clr    = (state == ST_IDLE) && cmd_valid;
    assign tb_wr_en  = (state == ST_WR) && last_word;
    assign tb_wr_idx = cur_obj;
    assign tb_wr_off = bump[PAGE_W-1:0];

    // Answer in-page lookups at boundaries; when idle a miss passes through.
    assign ans_valid = pend_in_page && at_boundary && (tb_rd_hit || state == ST_IDLE);
    assign ans_addr  = tb_rd_hit ? {dst_pg, tb_rd_off} : {src_page, pend_off};

    // Memory and free-list drive, decoded from the state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = mem_rdata;
        fl_we     = 1'b0;
        fl_addr   = {src_page, fl_cnt, {BLK_W{1'b0}}};
        case (state)
            ST_HDR:  begin mem_req = 1'b1; mem_addr = {src_page, cur_obj}; end
            ST_RD:   begin mem_req = 1'b1; mem_addr = {src_page, rd_off}; end
            ST_WR:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = {dst_pg, wr_off}; end
            ST_FREE: fl_we = 1'b1;
            default: ;
        endcase
    end

    // Sequencer: command intake, boundary arbitration, copy loop, block release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            src_page    <= '0;
            dst_pg      <= '0;
            page_active <= 1'b0;
            walk_ptr    <= '0;
            walk_done   <= 1'b0;
            cur_obj     <= '0;
            cur_size    <= '0;
            idx         <= '0;
            bump        <= '0;
            demand      <= 1'b0;
            fl_cnt      <= '0;
        end else begin
            case (state)
                ST_IDLE: if (cmd_valid) begin
                    src_page    <= cmd_src;
                    dst_pg      <= cmd_dst;
                    page_active <= 1'b1;
                    walk_ptr    <= '0;
                    walk_done   <= 1'b0;
                    bump        <= '0;
                    state       <= ST_PICK;
                end
                ST_PICK: begin
                    if (pend_in_page && !tb_rd_hit) begin
                        cur_obj <= pend_off;
                        demand  <= 1'b1;
                        state   <= ST_HDR;
                    end else if (pend_in_page) begin
                        state <= ST_PICK;
                    end else if (!walk_done && walk_ptr < PAGE_WORDS) begin
                        cur_obj <= walk_ptr[PAGE_W-1:0];
                        demand  <= 1'b0;
                        state   <= ST_HDR;
                    end else begin
                        fl_cnt <= '0;
                        state  <= ST_FREE;
                    end
                end
                ST_HDR: state <= ST_HDRW;
                ST_HDRW: begin
                    idx <= '0;
                    if (demand) begin
                        cur_size <= (hsize == '0) ? (PAGE_W+1)'(1) : hsize;
                        state    <= ST_RD;
                    end else if (hsize == '0) begin
                        walk_done <= 1'b1;
                        state     <= ST_PICK;
                    end else if (tb_rd_hit) begin
                        walk_ptr <= walk_ptr + hsize;
                        state    <= ST_PICK;
                    end else begin
                        cur_size <= hsize;
                        state    <= ST_RD;
                    end
                end
                ST_RD: state <= ST_WR;
                ST_WR: begin
                    if (last_word) begin
                        bump <= bump + cur_size;
                        if (!demand) walk_ptr <= walk_ptr + cur_size;
                        state <= ST_PICK;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_RD;
                    end
                end
                ST_FREE: begin
                    fl_cnt <= fl_cnt + 1'b1;
                    if (fl_cnt == '1) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: copies land only in the destination page.
    a_r4_dst_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr[ADDR_W-1:PAGE_W] == dst_pg);
    // R4: every write is preceded by the read that fetched its data.
    a_r4_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> $past(mem_req && !mem_we));
    // R8: consecutive free-list writes step by one block.
    a_r8_fl_step: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we && $past(fl_we) |-> fl_addr == $past(fl_addr) + BLK_WORDS);
    // R3: the bump pointer never passes the end of the destination page.
    a_r3_bump_limit: assert property (@(posedge clk) disable iff (!rst_n)
        bump <= PAGE_WORDS);
    // R9: a command during an evacuation leaves the destination unchanged.
    a_r9_busy_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_valid |=> $stable(dst_pg));
endmodule

// File: rtl/reloc_fwd_unit.sv
// Top level: evacuates one page into another, keeps the old-to-new mapping
// and answers pointer lookups, copying on demand. Assumes a memory with
// one-cycle read latency and one outstanding lookup at a time.
module reloc_fwd_unit #(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 6,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-PAGE_W-1:0] cmd_src_page,
    input  logic [ADDR_W-PAGE_W-1:0] cmd_dst_page,
    output logic              busy,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr
);
    localparam int PG_W = ADDR_W - PAGE_W;

    logic              page_active, pend_in_page, ans_valid;
    logic [PG_W-1:0]   src_page;
    logic [PAGE_W-1:0] pend_off;
    logic [ADDR_W-1:0] ans_addr;
    logic              tb_clr, tb_wr_en, tb_rd_hit;
    logic [PAGE_W-1:0] tb_wr_idx, tb_wr_off, tb_rd_idx, tb_rd_off;

    rfu_lookup_front #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_front (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .page_active(page_active), .src_page(src_page),
        .ans_valid(ans_valid), .ans_addr(ans_addr),
        .pend_in_page(pend_in_page), .pend_off(pend_off),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr));

    rfu_evac_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_src(cmd_src_page), .cmd_dst(cmd_dst_page), .busy(busy),
        .page_active(page_active), .src_page(src_page),
        .pend_in_page(pend_in_page), .pend_off(pend_off),
        .ans_valid(ans_valid), .ans_addr(ans_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .fl_we(fl_we), .fl_addr(fl_addr),
        .tb_clr(tb_clr), .tb_wr_en(tb_wr_en), .tb_wr_idx(tb_wr_idx),
        .tb_wr_off(tb_wr_off), .tb_rd_idx(tb_rd_idx),
        .tb_rd_hit(tb_rd_hit), .tb_rd_off(tb_rd_off));

    rfu_fwd_table #(.PAGE_W(PAGE_W)) u_table (
        .clk(clk), .rst_n(rst_n), .clr(tb_clr), .wr_en(tb_wr_en),
        .wr_idx(tb_wr_idx), .wr_off(tb_wr_off), .rd_idx(tb_rd_idx),
        .rd_hit(tb_rd_hit), .rd_off(tb_rd_off));
endmodule

// File: tb/sim_reloc_fwd_unit.sv
module sim_reloc_fwd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_src_page = '0, cmd_dst_page = '0;
    logic        busy;
    logic        lk_valid = 1'b0;
    logic [9:0]  lk_addr = '0;
    logic        rsp_valid;
    logic [9:0]  rsp_addr;
    logic        mem_req, mem_we;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        fl_we;
    logic [9:0]  fl_addr;

    int checks = 0, errors = 0;
    int wr_cnt = 0;
    int exp_dst = 0;
    int fl_q[$];
    bit fl_seen = 0;
    bit finished = 0;
    logic [9:0] last_rd = '0;
    logic [15:0] mem [0:1023];

    always #2 clk = ~clk;

    reloc_fwd_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_src_page(cmd_src_page), .cmd_dst_page(cmd_dst_page), .busy(busy),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .rsp_valid(rsp_valid),
        .rsp_addr(rsp_addr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .fl_we(fl_we), .fl_addr(fl_addr));

    // Behavioural memory with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Per-clock reference comparison of memory and free-list traffic.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && fl_seen) chk("R8 no memory access after free-list start", 1, 0);
            if (mem_req && !mem_we) last_rd = mem_addr;
            if (mem_req && mem_we) begin
                wr_cnt++;
                chk("R4 write page", int'(mem_addr[9:6]), exp_dst);
                chk("R4 write data", int'(mem_wdata), int'(mem[last_rd]));
            end
            if (fl_we) begin
                fl_seen = 1;
                fl_q.push_back(int'(fl_addr));
            end
        end
    end

    task automatic lookup(input int a, output int r, output int lat);
        lk_addr = 10'(a); lk_valid = 1'b1;
        @(negedge clk); lk_valid = 1'b0; lat = 1;
        while (!rsp_valid && lat < 2000) begin @(negedge clk); lat++; end
        r = int'(rsp_addr);
    endtask

    task automatic start(input int s, input int d);
        cmd_src_page = 4'(s); cmd_dst_page = 4'(d); cmd_valid = 1'b1;
        exp_dst = d; wr_cnt = 0; fl_seen = 0; fl_q.delete();
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic place(input int base, input int sz[]);
        int off = 0;
        foreach (sz[i]) begin
            mem[base+off] = 16'h5A00 | 16'(sz[i]);
            for (int w = 1; w < sz[i]; w++) mem[base+off+w] = 16'((base+off+w)*37 + 11);
            off += sz[i];
        end
    endtask

    task automatic check_obj(input string req, input int src, input int dst, input int sz);
        int bad = 0;
        for (int w = 0; w < sz; w++) if (mem[dst+w] !== mem[src+w]) bad++;
        chk(req, bad, 0);
    endtask

    task automatic check_free(input int base);
        chk("R8 free-list count", fl_q.size(), 4);
        for (int i = 0; i < 4 && i < fl_q.size(); i++) chk("R8 free-list address", fl_q[i], base + 16*i);
    endtask

    initial begin
        int r, lat, off, nz;
        int sa[] = '{3, 1, 5, 2, 4};
        int sb[] = '{4, 6, 2, 3};
        int sc[] = '{10, 2};
        int boff[] = '{0, 4, 10, 12};
        int bexp[] = '{387, 391, 397, 384};
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        place(128, sa); place(192, sb); place(256, sc);
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 rsp_valid in reset", int'(rsp_valid), 0);
        chk("R1 mem_req in reset", int'(mem_req), 0);
        chk("R1 fl_we in reset", int'(fl_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);

        // R2: pass-through before any command.
        lookup(200, r, lat);
        chk("R2 pass-through value", r, 200);
        chk("R2 pass-through latency", lat, 2);

        // Scenario A: pure background walk (R3, R4, R5, R8).
        start(2, 5);
        wait_idle();
        chk("R3 walk write count", wr_cnt, 15);
        off = 0;
        foreach (sa[i]) begin
            lookup(128 + off, r, lat);
            chk("R3 packed address", r, 320 + off);
            chk("R5 moved lookup latency", lat, 2);
            check_obj("R4 copied contents", 128 + off, r, sa[i]);
            off += sa[i];
        end
        check_free(128);
        lookup(37, r, lat);
        chk("R2 other-page value", r, 37);
        chk("R2 other-page latency", lat, 2);

        // Scenario B: lookup with the command (R6), ignored command (R9).
        fl_seen = 0; fl_q.delete();
        cmd_src_page = 4'd3; cmd_dst_page = 4'd6; cmd_valid = 1'b1;
        exp_dst = 6; wr_cnt = 0;
        lk_addr = 10'd204; lk_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0; lk_valid = 1'b0; lat = 1;
        while (!rsp_valid && lat < 2000) begin @(negedge clk); lat++; end
        chk("R6 on-demand address", int'(rsp_addr), 384);
        chk("R9 busy before second command", int'(busy), 1);
        cmd_src_page = 4'd4; cmd_dst_page = 4'd7; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        wait_idle();
        chk("R7 write count B", wr_cnt, 15);
        for (int i = 0; i < 4; i++) begin
            lookup(192 + boff[i], r, lat);
            chk("R6 address after demand", r, bexp[i]);
            check_obj("R4 copied contents B", 192 + boff[i], r, sb[i]);
        end
        nz = 0;
        for (int i = 448; i < 512; i++) if (mem[i] != 16'h0) nz++;
        chk("R9 ignored page untouched", nz, 0);
        check_free(192);

        // Scenario C: lookup of the object being copied (R7).
        start(4, 8);
        repeat (3) @(negedge clk);
        lookup(256, r, lat);
        chk("R7 in-copy lookup address", r, 512);
        wait_idle();
        chk("R7 write count C", wr_cnt, 12);
        lookup(266, r, lat);
        chk("R3 second object C", r, 522);
        check_obj("R4 copied contents C", 256, 512, 10);
        check_free(256);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule